// File: doc/BRIEF.md
# Two-Source Serial Interrupt Arbiter

This block combines the interrupt requests of two serial units into one prioritized request toward a processor. One unit is a synchronous serial port and the other is an asynchronous serial port. Software gives each source a 3-bit priority level. Level 0 turns a source off and level 7 is the most urgent. The block looks at the pending sources and picks a winner. It then raises one of seven request lines, chosen by the winner's level.

The processor answers with an acknowledge that carries the level it is servicing. If that level matches the current winner's level, the block returns an 8-bit vector on the next cycle, together with a one-cycle strobe. The upper seven vector bits come from a register that software sets. The block itself supplies the lowest bit, which tells the two sources apart.

A small register bus reaches two words: the level word and the vector word. The arbiter never clears a request. Each serial unit withdraws its own request once it has been serviced.

Top module: `serint_arbiter`

## Requirements
- R1: After reset, the level word reads 0x0000, the vector word reads 0x000F, all request lines are inactive and the vector strobe is low.
- R2: The level word is at address 0. The synchronous-port level sits in bits [10:8] and the asynchronous-port level sits in bits [2:0]. All other bits read as 0, and writes to them are ignored. A write takes effect at the next clock edge.
- R3: A source whose level is 0 never causes a request, whatever its request input does.
- R4: The request output is one-hot or all zero. Bit L-1 is high exactly when the winning pending level is L, for L from 1 to 7. When the two pending levels differ, the higher level wins.
- R5: When both sources request at the same nonzero level, the synchronous port wins.
- R6: An acknowledge with a nonzero level equal to the winning level raises the vector strobe for the next cycle. Any other acknowledge, and every cycle with no acknowledge, leaves the strobe low and the vector output at 0.
- R7: The vector output takes bits [7:1] from the vector word. Its bit 0 is 1 when the synchronous port won the acknowledge and 0 when the asynchronous port won.
- R8: The vector word is at address 1. Writes to its bit 0 are ignored and reads return 1 in that bit. Bits [15:8] read as 0.
- R9: An acknowledge does not clear a request. The request lines stay as they were until a source input or a level changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sync_req | input | 1 | Request from the synchronous serial port |
| async_req | input | 1 | Request from the asynchronous serial port |
| reg_addr | input | 1 | Register select: 0 is the level word, 1 is the vector word |
| reg_we | input | 1 | Write enable |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data of the selected word (combinational) |
| irq_lines | output | 7 | Request lines; bit i stands for level i+1 |
| ack_valid | input | 1 | An acknowledge cycle is in progress |
| ack_level | input | 3 | Level being acknowledged |
| vec_stb | output | 1 | Vector valid, for one cycle after a matching acknowledge |
| vec_out | output | 8 | Vector supplied on the strobe |

## Verification
The priority logic is driven in several ways:
- Directed cases separate the four main outcomes: a disabled source, a higher level winning in either direction, and an exact tie.
- Random level pairs and random request pairs, including zeros and ties, cover the whole compare space.

Each acknowledge is given either the winning level or a different one. This separates a correct match from a response to any acknowledge, and the returned bit 0 shows which source the block believed had won.

Register writes with every bit set expose bits that should not be stored and a vector bit 0 that should not be writable.

// File: rtl/serint_pkg.sv
package serint_pkg;
  localparam int LVL_W     = 3;
  localparam int NUM_LINES = (1 << LVL_W) - 1;

  typedef logic [LVL_W-1:0] lvl_t;

  typedef enum logic {
    SRC_ASYNC = 1'b0,
    SRC_SYNC  = 1'b1
  } src_e;

  // A source counts only when it is pending; otherwise its level is 0.
  function automatic lvl_t eff_level(input logic req, input lvl_t lvl);
    return req ? lvl : '0;
  endfunction

  // Level L maps to line L-1; level 0 gives no line.
  function automatic logic [NUM_LINES-1:0] lvl_to_lines(input lvl_t lvl);
    logic [NUM_LINES-1:0] lines;
    lines = '0;
    for (int i = 1; i <= NUM_LINES; i++) begin
      if (lvl == lvl_t'(i)) lines[i-1] = 1'b1;
    end
    return lines;
  endfunction

  // The synchronous port wins when its level is nonzero and not lower.
  function automatic logic sync_wins(input lvl_t es, input lvl_t ea);
    return (es != '0) && (es >= ea);
  endfunction
endpackage

// File: rtl/serint_regs.sv
module serint_regs
  import serint_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 8,
  parameter int SYNC_POS  = 8,
  parameter int ASYNC_POS = 0,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_addr,
  input  logic              reg_we,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output lvl_t              sync_lvl,
  output lvl_t              async_lvl,
  output logic [VEC_W-1:1]  vec_hi
);
  localparam logic ADDR_LVL = 1'b0;
  localparam logic ADDR_VEC = 1'b1;
  localparam logic [DATA_W-1:0] LVL_MASK =
    (DATA_W'((1 << LVL_W) - 1) << SYNC_POS) | (DATA_W'((1 << LVL_W) - 1) << ASYNC_POS);
  localparam logic [DATA_W-1:0] VEC_MASK = DATA_W'((1 << VEC_W) - 2);

  logic wr_lvl, wr_vec;
  assign wr_lvl = reg_we && (reg_addr == ADDR_LVL);
  assign wr_vec = reg_we && (reg_addr == ADDR_VEC);

  // Bits with no storage behind them are dropped on purpose.
  logic unused_wbits;
  assign unused_wbits = ^(reg_wdata & ~(LVL_MASK | VEC_MASK));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_lvl  <= '0;
      async_lvl <= '0;
      vec_hi    <= VEC_RST[VEC_W-1:1];
    end else begin
      if (wr_lvl) begin
        sync_lvl  <= reg_wdata[SYNC_POS  +: LVL_W];
        async_lvl <= reg_wdata[ASYNC_POS +: LVL_W];
      end
      if (wr_vec) vec_hi <= reg_wdata[VEC_W-1:1];
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (reg_addr == ADDR_LVL) begin
      reg_rdata[SYNC_POS  +: LVL_W] = sync_lvl;
      reg_rdata[ASYNC_POS +: LVL_W] = async_lvl;
    end else begin
      reg_rdata[VEC_W-1:1] = vec_hi;
      reg_rdata[0]         = 1'b1;
    end
  end

  // R8
  vec_lsb_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_addr == ADDR_VEC) |-> (reg_rdata[0] && reg_rdata[DATA_W-1:VEC_W] == '0));

  // R2
  lvl_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_lvl |=> ($stable(sync_lvl) && $stable(async_lvl)));
endmodule

// File: rtl/serint_prio.sv
module serint_prio
  import serint_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_req,
  input  logic                 async_req,
  input  lvl_t                 sync_lvl,
  input  lvl_t                 async_lvl,
  output lvl_t                 win_lvl,
  output src_e                 win_src,
  output logic [NUM_LINES-1:0] irq_lines
);
  lvl_t eff_s, eff_a;
  logic s_win;

  assign eff_s = eff_level(sync_req,  sync_lvl);
  assign eff_a = eff_level(async_req, async_lvl);
  assign s_win = sync_wins(eff_s, eff_a);

  always_comb begin
    if (s_win) begin
      win_src = SRC_SYNC;
      win_lvl = eff_s;
    end else begin
      win_src = SRC_ASYNC;
      win_lvl = eff_a;
    end
  end

  assign irq_lines = lvl_to_lines(win_lvl);

  // R4
  irq_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(irq_lines));

  // R3
  lvl_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_lvl == '0 && async_lvl == '0) |-> (irq_lines == '0));

  // R5
  tie_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sync_req && async_req && sync_lvl == async_lvl && sync_lvl != '0)
      |-> (win_src == SRC_SYNC));
endmodule

// File: rtl/serint_ack.sv
module serint_ack
  import serint_pkg::*;
#(
  parameter int VEC_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ack_valid,
  input  lvl_t             ack_level,
  input  lvl_t             win_lvl,
  input  src_e             win_src,
  input  logic [VEC_W-1:1] vec_hi,
  output logic             vec_stb,
  output logic [VEC_W-1:0] vec_out
);
  logic ack_hit;
  assign ack_hit = ack_valid && (ack_level != '0) && (ack_level == win_lvl);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vec_stb <= 1'b0;
      vec_out <= '0;
    end else begin
      vec_stb <= ack_hit;
      vec_out <= ack_hit ? {vec_hi, win_src == SRC_SYNC} : '0;
    end
  end

  // R6
  stb_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> $past(ack_valid && ack_level != '0));

  // R7
  vec_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    vec_stb |-> (vec_out[0] == $past(win_src == SRC_SYNC)));

  // R6
  idle_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !vec_stb |-> (vec_out == '0));
endmodule

// File: rtl/serint_arbiter.sv
module serint_arbiter
  import serint_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int VEC_W     = 8,
  parameter int SYNC_POS  = 8,
  parameter int ASYNC_POS = 0,
  parameter logic [VEC_W-1:0] VEC_RST = 8'h0F
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 sync_req,
  input  logic                 async_req,
  input  logic                 reg_addr,
  input  logic                 reg_we,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic [NUM_LINES-1:0] irq_lines,
  input  logic                 ack_valid,
  input  logic [LVL_W-1:0]     ack_level,
  output logic                 vec_stb,
  output logic [VEC_W-1:0]     vec_out
);
  lvl_t             sync_lvl, async_lvl, win_lvl;
  src_e             win_src;
  logic [VEC_W-1:1] vec_hi;

  serint_regs #(
    .DATA_W(DATA_W), .VEC_W(VEC_W), .SYNC_POS(SYNC_POS),
    .ASYNC_POS(ASYNC_POS), .VEC_RST(VEC_RST)
  ) regs_i (
    .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_we(reg_we),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .sync_lvl(sync_lvl), .async_lvl(async_lvl), .vec_hi(vec_hi)
  );

  serint_prio prio_i (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .async_req(async_req),
    .sync_lvl(sync_lvl), .async_lvl(async_lvl),
    .win_lvl(win_lvl), .win_src(win_src), .irq_lines(irq_lines)
  );

  serint_ack #(.VEC_W(VEC_W)) ack_i (
    .clk(clk), .rst_n(rst_n), .ack_valid(ack_valid), .ack_level(ack_level),
    .win_lvl(win_lvl), .win_src(win_src), .vec_hi(vec_hi),
    .vec_stb(vec_stb), .vec_out(vec_out)
  );

  // R9
  ack_keeps_irq_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(vec_stb == 1'b0) && vec_stb && $stable(sync_req) && $stable(async_req)
     && $stable(sync_lvl) && $stable(async_lvl)) |-> (irq_lines != '0));
endmodule

// File: tb/serint_arbiter_tb.sv
module serint_arbiter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        sync_req = 1'b0, async_req = 1'b0;
  logic        reg_addr = 1'b0, reg_we = 1'b0;
  logic [15:0] reg_wdata = '0;
  logic [15:0] reg_rdata;
  logic [6:0]  irq_lines;
  logic        ack_valid = 1'b0;
  logic [2:0]  ack_level = '0;
  logic        vec_stb;
  logic [7:0]  vec_out;

  int total = 0;
  int bad = 0;
  bit done = 1'b0;

  // Shadow of what software wrote, used to predict outcomes.
  logic [2:0] m_sl = '0, m_al = '0;
  logic [7:1] m_vh = 7'h07;

  always #5 clk = ~clk;

  serint_arbiter dut_i (
    .clk(clk), .rst_n(rst_n), .sync_req(sync_req), .async_req(async_req),
    .reg_addr(reg_addr), .reg_we(reg_we), .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata), .irq_lines(irq_lines), .ack_valid(ack_valid),
    .ack_level(ack_level), .vec_stb(vec_stb), .vec_out(vec_out)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // Returns {sync_won, winning level}.
  function automatic logic [3:0] pick(input logic sr, input logic ar,
                                      input logic [2:0] sl, input logic [2:0] al);
    logic [2:0] ls, la;
    ls = sr ? sl : 3'd0;
    la = ar ? al : 3'd0;
    if (ls == 0 && la == 0) return 4'd0;
    if (ls != 0 && !(la > ls)) return {1'b1, ls};
    return {1'b0, la};
  endfunction

  function automatic logic [6:0] lines_for(input logic [2:0] l);
    return (l == 0) ? 7'd0 : (7'd1 << (l - 1));
  endfunction

  task automatic wr(input logic a, input logic [15:0] d);
    @(negedge clk);
    reg_addr = a; reg_we = 1'b1; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic a, output logic [15:0] d);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic set_lvls(input logic [2:0] sl, input logic [2:0] al);
    wr(1'b0, {5'd0, sl, 5'd0, al});
    m_sl = sl; m_al = al;
  endtask

  // Drives the sources, checks the lines, then acknowledges at lvl.
  task automatic trial(input string rq, input logic sr, input logic ar,
                       input logic [2:0] lvl);
    logic [3:0] w;
    logic       hit;
    @(negedge clk);
    sync_req = sr; async_req = ar;
    w = pick(sr, ar, m_sl, m_al);
    #1 chk({rq, " lines"}, 32'(irq_lines), 32'(lines_for(w[2:0])));
    @(negedge clk);
    ack_valid = 1'b1; ack_level = lvl;
    hit = (lvl != 0) && (lvl == w[2:0]);
    @(negedge clk);
    ack_valid = 1'b0;
    #1;
    chk({rq, " R6 stb"}, 32'(vec_stb), 32'(hit));
    chk({rq, " R7 vec"}, 32'(vec_out), hit ? 32'({m_vh, w[3]}) : 32'd0);
    // R9: request lines unchanged after the acknowledge
    chk({rq, " R9 hold"}, 32'(irq_lines), 32'(lines_for(w[2:0])));
    @(negedge clk);
    #1 chk({rq, " R6 drop"}, 32'(vec_stb), 32'd0);
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    logic [15:0] d;
    logic [31:0] seed;
    seed = $urandom(32'd2024);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(1'b0, d); chk("R1 level word", 32'(d), 32'h0000);
    rd(1'b1, d); chk("R1 vector word", 32'(d), 32'h000F);
    chk("R1 lines", 32'(irq_lines), 32'd0);
    chk("R1 strobe", 32'(vec_stb), 32'd0);

    // R3 sources enabled in hardware but levels still 0
    trial("R3 reset levels", 1'b1, 1'b1, 3'd1);

    // R2 layout and ignored bits
    wr(1'b0, 16'hFFFF);
    rd(1'b0, d); chk("R2 all ones", 32'(d), 32'h0707);
    m_sl = 3'd7; m_al = 3'd7;
    set_lvls(3'd5, 3'd2);
    rd(1'b0, d); chk("R2 fields", 32'(d), 32'h0502);

    // R8 vector bit 0 and upper byte
    wr(1'b1, 16'hFFFE);
    rd(1'b1, d); chk("R8 write ones", 32'(d), 32'h00FF);
    wr(1'b1, 16'h0040); m_vh = 7'h20;
    rd(1'b1, d); chk("R8 lsb forced", 32'(d), 32'h0041);

    // R4 higher level wins in both directions
    trial("R4 sync higher", 1'b1, 1'b1, 3'd5);
    set_lvls(3'd2, 3'd6);
    trial("R4 async higher", 1'b1, 1'b1, 3'd6);
    trial("R6 wrong level", 1'b1, 1'b1, 3'd2);
    // R3 disabled sync source with a pending request
    set_lvls(3'd0, 3'd3);
    trial("R3 sync off", 1'b1, 1'b1, 3'd3);
    trial("R3 sync off alone", 1'b1, 1'b0, 3'd0);
    // R5 tie goes to the synchronous port
    set_lvls(3'd4, 3'd4);
    trial("R5 tie", 1'b1, 1'b1, 3'd4);
    trial("R5 async alone", 1'b0, 1'b1, 3'd4);
    trial("R6 zero ack", 1'b0, 1'b0, 3'd0);

    // Random mix
    for (int i = 0; i < 80; i++) begin
      logic [2:0] sl, al, lv;
      logic [3:0] w;
      logic       sr, ar;
      sl = 3'($urandom()); al = 3'($urandom());
      if ($urandom() % 4 == 0) al = sl;
      sr = 1'($urandom()); ar = 1'($urandom());
      if ($urandom() % 5 == 0) begin
        wr(1'b1, 16'($urandom())); m_vh = reg_wdata[7:1];
      end
      set_lvls(sl, al);
      w = pick(sr, ar, sl, al);
      lv = ($urandom() % 2 == 0) ? w[2:0] : 3'($urandom());
      trial("R4 random", sr, ar, lv);
    end

    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule